// File: doc/BRIEF.md
# Four-Write Two-Read Register File with Live-Value Table

This block is a register-file style memory of 144 words of 78 bits. It accepts up to four writes and two reads in every cycle, all on one system clock. No faster clock is used to time-share a single storage array. Each write port has its own private storage bank, and only that port's writes reach it. A small table beside the banks holds, for every entry, the number of the write port that last stored to it. A read port looks up that table at its address and selects the word from the bank it names.

The memory sits inside a pipeline that needs several results retired per cycle, as a multi-ported register file does. Every request on every port is accepted in the cycle it is presented. There is no ready signal and no back-pressure: a write enable or read enable that is high at a rising edge is always consumed at that edge. A read answers one cycle later, together with a valid flag. The read result stays on the output until the next accepted read on that port. Because of this, a consumer that stalls simply holds off its next read enable.

Top module: `lvt_ram`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `rd_vld` is 0 and `rd_data` is 0. A read of any in-range entry that has not been written since the last reset returns 0, even if the storage still holds older data.
- R2: A read accepted at edge N (`rd_en[r]`=1) drives `rd_vld[r]`=1 and the stored word on `rd_data[r]` from edge N+1 until the next edge.
- R3: Four writes to four distinct in-range addresses in one cycle are all kept, and each can be read back afterwards.
- R4: When several write ports write the same address in one cycle, the word from the highest-numbered of those ports is the one that is stored.
- R5: A read at the same edge as a write to the same address returns the contents from before that write (read-before-write). The new word is returned from the next read onwards.
- R6: The two read ports are independent: in one cycle they may read different addresses, or the same address, and each returns its own word.
- R7: While `rd_en[r]` is 0, `rd_vld[r]` is 0 on the next cycle and `rd_data[r]` keeps its previous value.
- R8: Addresses 144 and above are out of range. A write to one changes no entry, and a read of one returns 0 with `rd_vld` set.
- R9: A later write from any port replaces an earlier write from a different port at the same address. The latest word is returned, whatever the port numbers are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every port samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the live table and read outputs |
| wr_en | input | 4 | Write enable, one bit per write port |
| wr_addr | input | 4 x 8 | Write address per port; element k belongs to write port k |
| wr_data | input | 4 x 78 | Write data per port |
| rd_en | input | 2 | Read enable, one bit per read port |
| rd_addr | input | 2 x 8 | Read address per read port |
| rd_data | output | 2 x 78 | Registered read data per read port |
| rd_vld | output | 2 | High for one cycle after each accepted read |

## Verification
Every result of this block appears exactly one edge after its stimulus. Read data and its valid flag follow the accepting edge by one. A write becomes visible to a read that is accepted at the next edge, and a read at the same edge sees the older word. The bench drives all inputs on the falling edge. When it drives a read, it computes the expected word from a flat 144-entry model, before applying that cycle's writes to the model in rising port order. It then compares at the following falling edge, so every comparison lands half a period after the register that produces it. A read that is not enabled is expected to leave the previous word unchanged at the same sampling point.

// File: rtl/lvt_ram_pkg.sv
`timescale 1ns/1ps
package lvt_ram_pkg;

  localparam int unsigned LVT_DEPTH_DEF = 144;
  localparam int unsigned LVT_WIDTH_DEF = 78;
  localparam int unsigned LVT_NWR_DEF   = 4;
  localparam int unsigned LVT_NRD_DEF   = 2;

  // bits needed to name one of n items (at least one bit)
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lvt_bank.sv
`timescale 1ns/1ps
// One private storage bank, written by a single write port, read by all read ports.
module lvt_bank #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned WIDTH = 78,
  parameter int unsigned NRD   = 2,
  parameter int unsigned AW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][WIDTH-1:0] rdata
);

  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic             w_ok;

  assign w_ok = ({1'b0, waddr} < LIMIT);

  always_ff @(posedge clk) begin
    if (we && w_ok) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = ({1'b0, raddr[r]} < LIMIT) ? mem[raddr[r]] : '0;
  end

  AST_BANK_KEEPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && w_ok) |=> (mem[$past(waddr)] == $past(wdata))) else $error("bank lost a write"); // R3

endmodule

// File: rtl/lvt_live_table.sv
`timescale 1ns/1ps
// Per-entry record of the last write port, plus a written-since-reset bit.
module lvt_live_table #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned NWR   = 4,
  parameter int unsigned NRD   = 2,
  parameter int unsigned AW    = 8,
  parameter int unsigned IW    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWR-1:0]         wr_en,
  input  logic [NWR-1:0][AW-1:0] wr_addr,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0]         rd_live,
  output logic [NRD-1:0][IW-1:0] rd_port
);

  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [DEPTH-1:0] live;
  logic [IW-1:0]    owner [DEPTH];
  logic [NWR-1:0]   w_ok;
  logic [NRD-1:0]   r_ok;

  for (genvar k = 0; k < NWR; k++) begin : g_wok
    assign w_ok[k] = wr_en[k] && ({1'b0, wr_addr[k]} < LIMIT);
  end

  // ascending loop: the highest-numbered port on a shared address lands last
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        owner[i] <= '0;
      end
    end else begin
      for (int k = 0; k < int'(NWR); k++) begin
        if (w_ok[k]) begin
          live[wr_addr[k]]  <= 1'b1;
          owner[wr_addr[k]] <= IW'(k);
        end
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign r_ok[r]    = ({1'b0, rd_addr[r]} < LIMIT);
    assign rd_live[r] = r_ok[r] ? live[rd_addr[r]]  : 1'b0;
    assign rd_port[r] = r_ok[r] ? owner[rd_addr[r]] : '0;
  end

  AST_TOP_PORT_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    w_ok[NWR-1] |=> (live[$past(wr_addr[NWR-1])] &&
                     owner[$past(wr_addr[NWR-1])] == IW'(NWR-1))) else $error("top port lost ownership"); // R4

  AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ok == '0) |=> $stable(live)) else $error("table changed with no in-range write"); // R8

endmodule

// File: rtl/lvt_read_port.sv
`timescale 1ns/1ps
// One read port: picks the live bank's word and registers it.
module lvt_read_port #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned WIDTH = 78,
  parameter int unsigned NWR   = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned IW    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [AW-1:0]             rd_addr,
  input  logic                      live,
  input  logic [IW-1:0]             port,
  input  logic [NWR-1:0][WIDTH-1:0] bank_words,
  output logic [WIDTH-1:0]          rd_data,
  output logic                      rd_vld
);

  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic             a_ok;
  logic [WIDTH-1:0] pick;

  assign a_ok = ({1'b0, rd_addr} < LIMIT);

  always_comb begin
    pick = '0;
    if (a_ok && live) begin
      pick = bank_words[port];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) begin
        rd_data <= pick;
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)) else $error("read data moved without a read"); // R7

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !a_ok) |=> (rd_data == '0)) else $error("out-of-range read not zero"); // R8

  AST_UNWRITTEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !live) |=> (rd_data == '0)) else $error("unwritten entry not zero"); // R1

endmodule

// File: rtl/lvt_ram.sv
`timescale 1ns/1ps
module lvt_ram
  import lvt_ram_pkg::*;
#(
  parameter int unsigned DEPTH = LVT_DEPTH_DEF,
  parameter int unsigned WIDTH = LVT_WIDTH_DEF,
  parameter int unsigned NWR   = LVT_NWR_DEF,
  parameter int unsigned NRD   = LVT_NRD_DEF,
  localparam int unsigned AW   = idx_bits(DEPTH),
  localparam int unsigned IW   = idx_bits(NWR)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWR-1:0]            wr_en,
  input  logic [NWR-1:0][AW-1:0]    wr_addr,
  input  logic [NWR-1:0][WIDTH-1:0] wr_data,
  input  logic [NRD-1:0]            rd_en,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][WIDTH-1:0] rd_data,
  output logic [NRD-1:0]            rd_vld
);

  logic [NWR-1:0][NRD-1:0][WIDTH-1:0] bank_q;
  logic [NRD-1:0][NWR-1:0][WIDTH-1:0] port_words;
  logic [NRD-1:0]                     live_r;
  logic [NRD-1:0][IW-1:0]             owner_r;

  for (genvar k = 0; k < NWR; k++) begin : g_bank
    lvt_bank #(
      .DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD), .AW(AW)
    ) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en[k]),
      .waddr (wr_addr[k]),
      .wdata (wr_data[k]),
      .raddr (rd_addr),
      .rdata (bank_q[k])
    );
    for (genvar r = 0; r < NRD; r++) begin : g_route
      assign port_words[r][k] = bank_q[k][r];
    end
  end

  lvt_live_table #(
    .DEPTH(DEPTH), .NWR(NWR), .NRD(NRD), .AW(AW), .IW(IW)
  ) table_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rd_live (live_r),
    .rd_port (owner_r)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_rport
    lvt_read_port #(
      .DEPTH(DEPTH), .WIDTH(WIDTH), .NWR(NWR), .AW(AW), .IW(IW)
    ) rport_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en[r]),
      .rd_addr    (rd_addr[r]),
      .live       (live_r[r]),
      .port       (owner_r[r]),
      .bank_words (port_words[r]),
      .rd_data    (rd_data[r]),
      .rd_vld     (rd_vld[r])
    );
  end

endmodule

// File: tb/lvt_ram_tb.sv
`timescale 1ns/1ps
module lvt_ram_tb_top;

  localparam int DEPTH = 144;
  localparam int WIDTH = 78;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       wr_en = '0;
  logic [3:0][7:0]  wr_addr = '0;
  logic [3:0][77:0] wr_data = '0;
  logic [1:0]       rd_en = '0;
  logic [1:0][7:0]  rd_addr = '0;
  logic [1:0][77:0] rd_data;
  logic [1:0]       rd_vld;

  always #5 clk = ~clk;

  lvt_ram dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld)
  );

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [WIDTH-1:0] ref_mem [DEPTH];
  logic [WIDTH-1:0] exp_q [2];

  typedef struct packed {
    logic [3:0]      wen;
    logic [3:0][7:0] wa;
    logic [7:0]      tag;
    logic [1:0]      ren;
    logic [1:0][7:0] ra;
    logic [3:0]      req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, {8'd0, 8'd0, 8'd0, 8'd5},     8'h11, 2'b11, {8'd5, 8'd5},     4'd5}, // R5 same-edge read sees old (zero)
    '{4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},     8'h00, 2'b11, {8'd6, 8'd5},     4'd2}, // R2 R6 read back port 0 word
    '{4'b1111, {8'd13, 8'd12, 8'd11, 8'd10}, 8'h22, 2'b00, {8'd0, 8'd0},     4'd3}, // R3 four distinct writes
    '{4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},     8'h00, 2'b11, {8'd11, 8'd10},   4'd3}, // R3
    '{4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},     8'h00, 2'b11, {8'd13, 8'd12},   4'd3}, // R3
    '{4'b1011, {8'd20, 8'd0, 8'd20, 8'd20},  8'h33, 2'b00, {8'd0, 8'd0},     4'd4}, // R4 ports 0,1,3 collide
    '{4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},     8'h00, 2'b11, {8'd20, 8'd20},   4'd4}, // R4 R6 same address both ports
    '{4'b0110, {8'd0, 8'd143, 8'd144, 8'd0}, 8'h44, 2'b00, {8'd0, 8'd0},     4'd8}, // R8 last entry and first out-of-range
    '{4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},     8'h00, 2'b11, {8'd144, 8'd143}, 4'd8}, // R8
    '{4'b0001, {8'd0, 8'd0, 8'd0, 8'd20},    8'h55, 2'b01, {8'd0, 8'd20},    4'd9}, // R9 R5 port 0 supersedes port 3
    '{4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},     8'h00, 2'b10, {8'd20, 8'd0},    4'd9}, // R9
    '{4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},     8'h00, 2'b00, {8'd1, 8'd2},     4'd7}  // R7 no read: outputs hold
  };

  function automatic logic [WIDTH-1:0] mk(input logic [7:0] tag, input int p);
    return {{8{tag}}, 6'(p), tag};
  endfunction

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after comparing
  task automatic run_cycle(input logic [3:0] wen, input logic [3:0][7:0] wa,
                           input logic [7:0] tag, input logic [1:0] ren,
                           input logic [1:0][7:0] ra, input int req);
    wr_en = wen;
    rd_en = ren;
    rd_addr = ra;
    for (int p = 0; p < 4; p++) begin
      wr_addr[p] = wa[p];
      wr_data[p] = mk(tag, p);
    end
    for (int r = 0; r < 2; r++) begin
      if (ren[r]) exp_q[r] = (int'(ra[r]) < DEPTH) ? ref_mem[ra[r]] : '0;
    end
    @(posedge clk);
    #1;
    for (int p = 0; p < 4; p++) begin
      if (wen[p] && int'(wa[p]) < DEPTH) ref_mem[wa[p]] = mk(tag, p);
    end
    @(negedge clk);
    for (int r = 0; r < 2; r++) begin
      chk(rd_vld[r] == ren[r], ren[r] ? 2 : 7, $sformatf("rd_vld[%0d]", r),
          WIDTH'(rd_vld[r]), WIDTH'(ren[r]));
      chk(rd_data[r] == exp_q[r], ren[r] ? req : 7, $sformatf("rd_data[%0d]", r),
          rd_data[r], exp_q[r]);
    end
  endtask

  task automatic idle();
    wr_en = '0;
    rd_en = '0;
  endtask

  function automatic logic [7:0] pick_addr();
    if ($urandom_range(0, 9) == 0) return 8'($urandom_range(140, 160));
    return 8'($urandom_range(0, 15));
  endfunction

  task automatic check_reset_outputs();
    for (int r = 0; r < 2; r++) begin
      chk(rd_vld[r] == 1'b0, 1, "reset rd_vld", WIDTH'(rd_vld[r]), '0); // R1
      chk(rd_data[r] == '0, 1, "reset rd_data", rd_data[r], '0);        // R1
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    exp_q[0] = '0;
    exp_q[1] = '0;
    repeat (3) @(negedge clk);
    check_reset_outputs();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_outputs();

    for (int v = 0; v < NV; v++) begin
      run_cycle(VECS[v].wen, VECS[v].wa, VECS[v].tag, VECS[v].ren, VECS[v].ra, int'(VECS[v].req));
    end
    idle();

    // R4 directed: all four ports on one address, read on the next cycle
    run_cycle(4'b1111, {8'd77, 8'd77, 8'd77, 8'd77}, 8'h66, 2'b00, {8'd0, 8'd0}, 4);
    run_cycle(4'b0000, '0, 8'h00, 2'b11, {8'd77, 8'd77}, 4);
    chk(rd_data[0] == mk(8'h66, 3), 4, "top port wins", rd_data[0], mk(8'h66, 3));

    // R1 mid-run reset: table forgets writes though banks still hold them
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    exp_q[0] = '0;
    exp_q[1] = '0;
    @(negedge clk);
    check_reset_outputs();
    rst_n = 1'b1;
    @(negedge clk);
    run_cycle(4'b0000, '0, 8'h00, 2'b11, {8'd77, 8'd5}, 1);

    // R6 random concurrent traffic on all ports
    for (int n = 0; n < 400; n++) begin
      run_cycle(4'($urandom), {pick_addr(), pick_addr(), pick_addr(), pick_addr()},
                8'($urandom), 2'($urandom), {pick_addr(), pick_addr()}, 6);
    end
    idle();
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule